// File: doc/BRIEF.md
# Isolation Link Frame Multiplexer

This block carries a voice-band channel across an isolation transformer as one serial stream. On the sending side it packs one 16-bit media sample and one 8-bit control or status word into a fixed 96-bit frame. It sends one such frame per half-sample period, because samples cross the link at twice the codec rate. The frame goes out bit by bit in a self-clocking two-level line code. On the receiving side it recovers bit timing from the transitions of that code alone, finds the frame boundary by hunting for a fixed sync pattern, and delivers the sample and the word once per frame.

The same module serves either end of the barrier. The host end feeds control words into the field. The line end feeds auxiliary-converter status words into it. Only the meaning of the 8-bit field differs. The receiving half holds frame alignment with a small lock machine, so that one damaged frame does not disturb the output. A longer disturbance mutes the sample output while keeping the last status word that was received.

Top module: `isolink_mux`

## Requirements
- R1: A frame is 96 bits sent most significant first: bits 0-7 are the sync pattern 8'hE4, bits 8-23 the sample (MSB first), bits 24-31 the field (MSB first), and bits 32-95 are zero fill.
- R2: Every bit occupies two half-symbols of HALF_CYC clock cycles each (default 4). A one is sent high then low and a zero low then high, so `line_out` changes in the middle of every bit and never holds one level for more than 2*HALF_CYC cycles.
- R3: `tx_load` is high for exactly one cycle, the first cycle of every frame, once every 96*2*HALF_CYC cycles. During reset it is high and `line_out` shows the first half of sync bit 0 (high). The frame that begins in that cycle carries the `tx_sample`/`tx_field` values present at the clock edge that starts the cycle. The first frame after reset carries zeros.
- R4: After reset `rx_locked`, `rx_valid`, `rx_sample` and `rx_field` are all 0.
- R5: The receiver declares lock only after three consecutive frames whose sync pattern sits at the expected 96-bit spacing. It is never locked before the third such sync. The first frame it delivers is the one that carried the third sync. The same rule applies when it locks again after losing lock.
- R6: While locked, each frame whose sync matches delivers its sample on `rx_sample` and its field on `rx_field`, with a single-cycle `rx_valid` pulse, before the next frame starts at the sender.
- R7: While locked, a single frame with a wrong sync keeps the lock but is not delivered: there is no `rx_valid`, and `rx_sample`/`rx_field` hold the previous frame's values. The next good frame is delivered normally.
- R8: A second consecutive sync miss drops lock. While unlocked, `rx_sample` is 0 and `rx_field` holds the last delivered field.
- R9: `rx_valid` is asserted only while `rx_locked` is high, and never in two consecutive cycles. No frame is delivered while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by sender and receiver; HALF_CYC cycles per half-symbol |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_sample | input | 16 | Sample to send, taken at the start of each frame |
| tx_field | input | 8 | Control or status word to send, taken with the sample |
| tx_load | output | 1 | Marks the first cycle of each outgoing frame |
| line_out | output | 1 | Line-coded serial stream toward the barrier |
| line_in | input | 1 | Line-coded serial stream from the barrier (asynchronous) |
| rx_sample | output | 16 | Last delivered sample; 0 while unlocked |
| rx_field | output | 8 | Last delivered control or status word |
| rx_valid | output | 1 | One-cycle pulse when a frame is delivered |
| rx_locked | output | 1 | Frame alignment established |

## Verification
The bench closes the loop from `line_out` to `line_in` through an inverter it can switch on at exact bit boundaries. This lets it damage only the eight sync bits of one frame, or every bit for a stretch of frames. A design that dropped lock on one miss would mute the sample, and one that delivered a damaged frame would show the corrupted payload instead of the previous one. A receiver that locked on fewer than three syncs would report lock one or two frames early after reset or after relocking. One that cleared the status word on lock loss would show 0 instead of the held value. One whole frame is also decoded from the raw line at half-symbol centres. This catches swapped field positions, a reversed bit order, the wrong line-code polarity or a missing mid-bit transition.

// File: rtl/isolink_pkg.sv
// Shared types for the isolation link frame multiplexer.
// Assumes: nothing beyond the standard language.
package isolink_pkg;

    // Receive alignment: searching every bit, confirming repeats, or locked.
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_t;

endpackage

// File: rtl/isolink_manch_enc.sv
// Half-symbol timer and two-level line encoder.
// Each bit is sent as two half-symbols of HALF_CYC cycles: a one as high/low,
// a zero as low/high. It marks the first and last cycle of every bit cell.
// Assumes: HALF_CYC >= 2; data_bit is stable for a whole bit cell.
module isolink_manch_enc #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_bit,
    output logic line_out,
    output logic bit_first,
    output logic bit_last
);
    localparam int unsigned HC_W = $clog2(HALF_CYC + 1);

    logic [HC_W-1:0] hcnt;
    logic            second_half;

    // Advance the half-symbol timer and flip halves at the end of each half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt        <= '0;
            second_half <= 1'b0;
        end else if (hcnt == HC_W'(HALF_CYC - 1)) begin
            hcnt        <= '0;
            second_half <= ~second_half;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Encode: the second half is the complement of the first.
    assign line_out  = data_bit ^ second_half;
    assign bit_first = !second_half && (hcnt == '0);
    assign bit_last  = second_half && (hcnt == HC_W'(HALF_CYC - 1));

endmodule

// File: rtl/isolink_tx_frame.sv
// Frame builder and serializer.
// It loads {sync, sample, field, zero fill} into a shift register at every
// frame boundary and shifts one bit per completed bit cell, MSB first.
// Assumes: FRAME_BITS > SYNC_W + SAMPLE_W + FIELD_W.
module isolink_tx_frame #(
    parameter int unsigned FRAME_BITS = 96,
    parameter int unsigned SYNC_W     = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hE4,
    parameter int unsigned SAMPLE_W   = 16,
    parameter int unsigned FIELD_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic [FIELD_W-1:0]  tx_field,
    input  logic                bit_first,
    input  logic                bit_last,
    output logic                data_bit,
    output logic                tx_load
);
    localparam int unsigned FILL_W = FRAME_BITS - SYNC_W - SAMPLE_W - FIELD_W;
    localparam int unsigned BI_W   = $clog2(FRAME_BITS);

    logic [BI_W-1:0]       bidx;
    logic [FRAME_BITS-1:0] shreg;

    // Shift out one bit per cell; reload the next frame after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx  <= '0;
            shreg <= {SYNC_WORD, {(FRAME_BITS - SYNC_W){1'b0}}};
        end else if (bit_last) begin
            if (bidx == BI_W'(FRAME_BITS - 1)) begin
                bidx  <= '0;
                shreg <= {SYNC_WORD, tx_sample, tx_field, {FILL_W{1'b0}}};
            end else begin
                bidx  <= bidx + 1'b1;
                shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign data_bit = shreg[FRAME_BITS-1];
    assign tx_load  = bit_first && (bidx == '0);

endmodule

// File: rtl/isolink_manch_dec.sv
// Clock recovery and line decoder.
// It synchronizes the asynchronous line and measures the gap since the last
// accepted mid-bit transition. A transition at least 1.5 half-symbol periods
// after it is a mid-bit transition, and the level before it is the bit value.
// Shorter gaps are cell-boundary transitions and are skipped.
// Assumes: HALF_CYC >= 2 cycles of clk per half-symbol.
module isolink_manch_dec #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_vld,
    output logic bit_val
);
    localparam int unsigned MID_MIN = (3 * HALF_CYC) / 2;
    localparam int unsigned GAP_MAX = 4 * HALF_CYC;
    localparam int unsigned GW      = $clog2(GAP_MAX + 1);

    logic          meta, synced, prev;
    logic [GW-1:0] gap;

    // Synchronize, detect transitions and emit one bit per mid-bit transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta    <= 1'b0;
            synced  <= 1'b0;
            prev    <= 1'b0;
            gap     <= GW'(GAP_MAX);
            bit_vld <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            meta    <= line_in;
            synced  <= meta;
            prev    <= synced;
            bit_vld <= 1'b0;
            if ((synced != prev) && (gap >= GW'(MID_MIN))) begin
                bit_vld <= 1'b1;
                bit_val <= prev;
                gap     <= GW'(1);
            end else if (gap != GW'(GAP_MAX)) begin
                gap <= gap + 1'b1;
            end
        end
    end

endmodule

// File: rtl/isolink_rx_align.sv
// Frame alignment and field extraction.
// In hunt it tests the sync pattern after every bit. After a hit it checks one
// fixed position per frame: LOCK_HITS hits in a row lock, and DROP_MISSES misses
// in a row while locked return to hunt. A locked frame with a good sync delivers
// its sample and field. A frame with a bad sync is dropped.
// Assumes: LOCK_HITS >= 2, DROP_MISSES >= 1, SAMPLE_W + FIELD_W >= SYNC_W.
module isolink_rx_align #(
    parameter int unsigned FRAME_BITS  = 96,
    parameter int unsigned SYNC_W      = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hE4,
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned LOCK_HITS   = 3,
    parameter int unsigned DROP_MISSES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_vld,
    input  logic                bit_val,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic [FIELD_W-1:0]  rx_field,
    output logic                rx_valid,
    output logic                rx_locked
);
    localparam int unsigned WIN_W    = SAMPLE_W + FIELD_W;
    localparam int unsigned PW       = $clog2(FRAME_BITS);
    localparam int unsigned HW       = $clog2(LOCK_HITS + 1);
    localparam int unsigned MW       = $clog2(DROP_MISSES + 1);
    localparam int unsigned SYNC_END = SYNC_W - 1;
    localparam int unsigned PAY_END  = SYNC_W + WIN_W - 1;

    isolink_pkg::align_state_t state;
    logic [WIN_W-2:0] hist;
    logic [WIN_W-1:0] win;
    logic             sync_hit;
    logic [PW-1:0]    pos;
    logic [HW-1:0]    hits;
    logic [MW-1:0]    misses;
    logic             frame_ok;

    // Window of the most recent bits, including the one arriving now.
    always_comb begin
        win      = {hist, bit_val};
        sync_hit = (win[SYNC_W-1:0] == SYNC_WORD);
    end

    assign rx_locked = (state == isolink_pkg::ST_LOCKED);

    // Track the bit position, run the lock machine and capture payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= isolink_pkg::ST_HUNT;
            hist      <= '0;
            pos       <= '0;
            hits      <= '0;
            misses    <= '0;
            frame_ok  <= 1'b0;
            rx_sample <= '0;
            rx_field  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (bit_vld) begin
                hist <= win[WIN_W-2:0];
                pos  <= (pos == PW'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
                case (state)
                    isolink_pkg::ST_HUNT: begin
                        if (sync_hit) begin
                            state    <= isolink_pkg::ST_VERIFY;
                            hits     <= HW'(1);
                            pos      <= PW'(SYNC_W);
                            frame_ok <= 1'b0;
                        end
                    end
                    isolink_pkg::ST_VERIFY: begin
                        if (pos == PW'(SYNC_END)) begin
                            if (!sync_hit) begin
                                state <= isolink_pkg::ST_HUNT;
                            end else if (hits == HW'(LOCK_HITS - 1)) begin
                                state    <= isolink_pkg::ST_LOCKED;
                                misses   <= '0;
                                frame_ok <= 1'b1;
                            end else begin
                                hits <= hits + 1'b1;
                            end
                        end
                    end
                    isolink_pkg::ST_LOCKED: begin
                        if (pos == PW'(SYNC_END)) begin
                            if (sync_hit) begin
                                misses   <= '0;
                                frame_ok <= 1'b1;
                            end else begin
                                frame_ok <= 1'b0;
                                if (misses == MW'(DROP_MISSES - 1)) begin
                                    state     <= isolink_pkg::ST_HUNT;
                                    rx_sample <= '0;
                                end else begin
                                    misses <= misses + 1'b1;
                                end
                            end
                        end else if ((pos == PW'(PAY_END)) && frame_ok) begin
                            rx_sample <= win[FIELD_W +: SAMPLE_W];
                            rx_field  <= win[FIELD_W-1:0];
                            rx_valid  <= 1'b1;
                        end
                    end
                    default: state <= isolink_pkg::ST_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/isolink_mux.sv
// Isolation link frame multiplexer, one end of the barrier.
// The send half builds one frame per half-sample period and line-codes it.
// The receive half recovers bit timing from the incoming code, aligns to the
// sync pattern and delivers the sample and the field.
// Assumes: line_in is asynchronous to clk but runs at the same nominal rate.
module isolink_mux #(
    parameter int unsigned HALF_CYC    = 4,
    parameter int unsigned FRAME_BITS  = 96,
    parameter int unsigned SYNC_W      = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hE4,
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned LOCK_HITS   = 3,
    parameter int unsigned DROP_MISSES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic [FIELD_W-1:0]  tx_field,
    output logic                tx_load,
    output logic                line_out,
    input  logic                line_in,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic [FIELD_W-1:0]  rx_field,
    output logic                rx_valid,
    output logic                rx_locked
);
    logic data_bit, bit_first, bit_last;
    logic dec_vld, dec_val;

    isolink_manch_enc #(.HALF_CYC(HALF_CYC)) u_enc (
        .clk(clk), .rst_n(rst_n), .data_bit(data_bit),
        .line_out(line_out), .bit_first(bit_first), .bit_last(bit_last)
    );

    isolink_tx_frame #(
        .FRAME_BITS(FRAME_BITS), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD),
        .SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)
    ) u_txf (
        .clk(clk), .rst_n(rst_n), .tx_sample(tx_sample), .tx_field(tx_field),
        .bit_first(bit_first), .bit_last(bit_last),
        .data_bit(data_bit), .tx_load(tx_load)
    );

    isolink_manch_dec #(.HALF_CYC(HALF_CYC)) u_dec (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .bit_vld(dec_vld), .bit_val(dec_val)
    );

    isolink_rx_align #(
        .FRAME_BITS(FRAME_BITS), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD),
        .SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W),
        .LOCK_HITS(LOCK_HITS), .DROP_MISSES(DROP_MISSES)
    ) u_aln (
        .clk(clk), .rst_n(rst_n), .bit_vld(dec_vld), .bit_val(dec_val),
        .rx_sample(rx_sample), .rx_field(rx_field),
        .rx_valid(rx_valid), .rx_locked(rx_locked)
    );

endmodule

// File: rtl/isolink_mux_chk.sv
// Property checker for the isolation link frame multiplexer, bound to the top.
// Assumes: the same parameter values as the instance it is bound to.
module isolink_mux_chk #(
    parameter int unsigned HALF_CYC = 4,
    parameter int unsigned SYNC_W   = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hE4,
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned FIELD_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_load,
    input logic                line_out,
    input logic [SAMPLE_W-1:0] rx_sample,
    input logic [FIELD_W-1:0]  rx_field,
    input logic                rx_valid,
    input logic                rx_locked
);
    localparam int unsigned RUN_MAX = 4 * HALF_CYC;
    localparam int unsigned RW      = $clog2(RUN_MAX + 1);

    logic [RW-1:0] run;
    logic          last_line;

    // Count how many cycles the line has held its current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= RW'(1);
            last_line <= line_out;
        end else begin
            last_line <= line_out;
            if (line_out != last_line) run <= RW'(1);
            else if (run != RW'(RUN_MAX)) run <= run + 1'b1;
        end
    end

    p_mid_transition_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(2 * HALF_CYC));

    p_frame_starts_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (line_out == SYNC_WORD[SYNC_W-1]));

    p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    p_valid_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_locked);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_unlocked_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_locked |-> (rx_sample == '0));

    p_field_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_field) |-> rx_valid);

    p_sample_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_sample) |-> (rx_valid || !rx_locked));

endmodule

bind isolink_mux isolink_mux_chk #(
    .HALF_CYC(HALF_CYC), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD),
    .SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .line_out(line_out),
    .rx_sample(rx_sample), .rx_field(rx_field),
    .rx_valid(rx_valid), .rx_locked(rx_locked)
);

// File: tb/sim_isolink_mux.sv
`timescale 1ns/1ps
// Bench: line_out loops to line_in through a switchable inverter.
module sim_isolink_mux;
    localparam int HALF = 4;
    localparam int NVEC = 12;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h1234_5A, 24'h0000_00, 24'hFFFF_FF, 24'h8000_01,
        24'hE4E4_E4, 24'h0001_80, 24'hBEEF_3C, 24'h7FFF_FE,
        24'h5555_AA, 24'hC0DE_42, 24'h0F0F_F0, 24'h9A3B_07
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_sample = '0;
    logic [7:0]  tx_field = '0;
    logic        flip = 1'b0;
    logic        tx_load, line_out, line_in, rx_valid, rx_locked;
    logic [15:0] rx_sample;
    logic [7:0]  rx_field;
    int          n_chk = 0, n_bad = 0, vcnt = 0;

    always #2 clk = ~clk;
    assign line_in = line_out ^ flip;

    isolink_mux u0 (
        .clk(clk), .rst_n(rst_n), .tx_sample(tx_sample), .tx_field(tx_field),
        .tx_load(tx_load), .line_out(line_out), .line_in(line_in),
        .rx_sample(rx_sample), .rx_field(rx_field),
        .rx_valid(rx_valid), .rx_locked(rx_locked)
    );

    always @(negedge clk) if (rx_valid) vcnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_load();
        do @(negedge clk); while (!tx_load);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v0;
        logic [95:0] expf;
        int fmt_err, cell_err, load_seen;
        logic fh, sh;

        repeat (5) @(negedge clk);
        chk("R3 tx_load in reset", {31'd0, tx_load}, 32'd1);
        chk("R3 line_out in reset", {31'd0, line_out}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset outputs", {rx_sample, rx_field, 6'd0, rx_valid, rx_locked}, 32'd0);

        // R5: at most two syncs seen after two frame starts -> not locked yet.
        wait_load(); wait_load();
        chk("R5 no early lock", {31'd0, rx_locked}, 32'd0);
        repeat (3) wait_load();
        chk("R5 locked after reset", {31'd0, rx_locked}, 32'd1);

        // R6: table walk, each vector sent in the frame after it is set.
        for (int i = 0; i < NVEC; i++) begin
            wait_load();
            tx_sample = VEC[i][23:8];
            tx_field  = VEC[i][7:0];
            v0 = vcnt;
            wait_load(); wait_load();
            chk($sformatf("R6 vector %0d payload", i), {8'd0, rx_sample, rx_field}, {8'd0, VEC[i]});
            chk($sformatf("R6 vector %0d valid count", i), vcnt - v0, 32'd2);
        end

        // R1/R2/R3: decode one whole frame from the raw line.
        wait_load();
        tx_sample = 16'hA5C3; tx_field = 8'h69;
        expf = {8'hE4, 16'hA5C3, 8'h69, 64'd0};
        wait_load();
        fmt_err = 0; cell_err = 0; load_seen = 0;
        for (int b = 0; b < 96; b++) begin
            fh = line_out;
            repeat (HALF) @(negedge clk);
            sh = line_out;
            for (int c = 0; c < HALF; c++) begin
                @(negedge clk);
                if (tx_load && !(b == 95 && c == HALF - 1)) load_seen++;
            end
            if (fh !== expf[95-b]) fmt_err++;
            if (sh === fh) cell_err++;
        end
        chk("R1 frame bits", fmt_err, 32'd0);
        chk("R2 mid-bit transitions", cell_err, 32'd0);
        chk("R3 next frame start", {31'd0, tx_load}, 32'd1);
        chk("R3 no extra tx_load", load_seen, 32'd0);

        // R7: damage only the sync bits of one locked frame.
        tx_sample = 16'h0F0F; tx_field = 8'h33;
        wait_load();
        tx_sample = 16'h7777; tx_field = 8'h44;
        wait_load();
        chk("R6 before damage", {8'd0, rx_sample, rx_field}, {8'd0, 16'h0F0F, 8'h33});
        tx_sample = 16'h1111; tx_field = 8'h55;
        v0 = vcnt;
        flip = 1'b1;
        repeat (16 * HALF) @(negedge clk);
        flip = 1'b0;
        wait_load();
        chk("R7 lock kept after one miss", {31'd0, rx_locked}, 32'd1);
        chk("R7 damaged frame dropped", {8'd0, rx_sample, rx_field}, {8'd0, 16'h0F0F, 8'h33});
        chk("R7 no valid for damaged frame", vcnt - v0, 32'd0);
        wait_load();
        chk("R7 next frame delivered", {8'd0, rx_sample, rx_field}, {8'd0, 16'h1111, 8'h55});

        // R8: invert everything for several frames.
        tx_sample = 16'hFFFF; tx_field = 8'hFF;
        wait_load(); wait_load();
        chk("R6 all-ones payload", {8'd0, rx_sample, rx_field}, {8'd0, 16'hFFFF, 8'hFF});
        flip = 1'b1;
        wait_load();
        chk("R7 first miss keeps lock", {31'd0, rx_locked}, 32'd1);
        chk("R7 first miss holds sample", {16'd0, rx_sample}, 32'h0000FFFF);
        wait_load();
        chk("R8 second miss drops lock", {31'd0, rx_locked}, 32'd0);
        chk("R8 sample muted", {16'd0, rx_sample}, 32'd0);
        chk("R8 field held", {24'd0, rx_field}, 32'h000000FF);
        v0 = vcnt;
        wait_load();
        chk("R9 no delivery while unlocked", vcnt - v0, 32'd0);
        chk("R8 still unlocked", {31'd0, rx_locked}, 32'd0);

        // R5: relock needs three fresh syncs.
        flip = 1'b0;
        tx_sample = 16'h2468; tx_field = 8'h9C;
        wait_load();
        chk("R5 relock not after one sync", {31'd0, rx_locked}, 32'd0);
        wait_load();
        chk("R5 relock not after two syncs", {31'd0, rx_locked}, 32'd0);
        wait_load();
        chk("R5 relocked on third sync", {31'd0, rx_locked}, 32'd1);
        chk("R5 third-sync frame delivered", {8'd0, rx_sample, rx_field}, {8'd0, 16'h2468, 8'h9C});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule